// File: doc/BRIEF.md
# Masked Multi-CPU Device Interrupt Router

The block collects up to 64 level-sensitive device interrupt lines into one shared raw-request register and routes them to as many as four processors. Each processor owns a mask register of the same width. A processor's hardware-interrupt output is high whenever at least one line is pending in the raw register and enabled in that processor's mask. One raw-request bit, line 55 by default, is driven by the output of a cascaded legacy interrupt controller rather than by the general line input.

Software reaches the block through a 32-bit register port. Each register is 64 bits wide and is accessed as two halves. Address bit 2 selects the upper half. Writing the lower half only loads a staging latch. Writing the upper half joins the new data with the latch and commits the full 64-bit value. Reading the lower half returns the low word and parks the high word in the same latch, where a following upper-half read picks it up. Each processor also has a read-only view of its mask ANDed with the raw requests.

Top module: `irq_router`

## Requirements
- R1: Raw-request bit n (n not equal to 55) equals the level of irq_lines[n] sampled at the previous rising clock edge; no edge is remembered.
- R2: Raw-request bit 55 equals cascade_irq sampled at the previous rising edge; irq_lines[55] has no effect on the block.
- R3: While rst_n is low, all masks and the raw-request register are zero, every cpu_irq is low, and rsp_valid and rsp_err are low.
- R4: cpu_irq[c] is high exactly when the registered mask of CPU c ANDed with the registered raw requests is nonzero, and it follows a change of either operand in the same cycle that the register changes.
- R5: Byte offsets are as follows. The masks of CPU0 to CPU3 are at 0x200, 0x240, 0x600 and 0x640. The masked views of CPU0 to CPU3 are at 0x280, 0x2C0, 0x680 and 0x6C0. The raw-request register is at 0x300. acc_addr[2] selects the upper word, and acc_addr[1:0] must be zero.
- R6: A write with acc_addr[2]=0 only loads the staging latch and changes no register. A write with acc_addr[2]=1 commits {acc_wdata, latch} to the register at acc_addr with bit 2 cleared, visible from the next cycle.
- R7: Every access produces rsp_valid one cycle later. A read with acc_addr[2]=0 returns bits 31:0 of the register in rsp_rdata and stores bits 63:32 in the latch. A read with acc_addr[2]=1 returns the latch.
- R8: Upper-half writes to a masked view or to the raw-request register change nothing and raise no error.
- R9: A lower-half read or an upper-half write to an unmapped or misaligned offset sets rsp_err for exactly one cycle, and the read returns all ones. Such an access leaves the latch unchanged. Lower-half writes and upper-half reads never raise rsp_err.
- R10: A read of CPU c's masked view returns the mask of CPU c ANDed with the raw-request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Level device interrupt lines |
| cascade_irq | input | 1 | Output of the cascaded legacy interrupt controller |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 12 | Byte offset of the 32-bit half |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped-access pulse |
| cpu_irq | output | 4 | Per-CPU hardware interrupt request |

## Verification
A corrupted mask or raw bit shows on cpu_irq in the cycle it is stored, provided its partner operand has the bit set. The corruption is also visible on the next read of the mask, the view or the raw register. A wrong staging latch does not show until the next upper-half access: a committed write lands the wrong low word, or an upper-half read returns stale data. For this reason the stimulus interleaves unmapped reads and lone lower-half writes between the halves of real accesses.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int REG_W  = 64;
   localparam int HALF_W = 32;
   localparam int OFF_W  = 12;
   localparam logic [OFF_W-1:0] OFF_RAW = 12'h300;

   // CPU0/1 masks sit in the low bank, CPU2/3 in the high bank
   function automatic logic [OFF_W-1:0] mask_off(input int c);
      if (c < 2) return 12'h200 + 12'(c * 64);
      else       return 12'h600 + 12'((c - 2) * 64);
   endfunction

   function automatic logic [OFF_W-1:0] view_off(input int c);
      return mask_off(c) + 12'h080;
   endfunction
endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
   parameter int NUM_LINES    = 64,
   parameter int CASCADE_LINE = 55
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   input  logic                 cascade_i,
   output logic [NUM_LINES-1:0] raw_o
);
   logic [NUM_LINES-1:0] next_raw;

   always_comb begin
      next_raw               = lines_i;
      next_raw[CASCADE_LINE] = cascade_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_o <= '0;
      else        raw_o <= next_raw;
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPU   = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_CPU-1:0]                 we_i,
   input  logic [NUM_LINES-1:0]               wdata_i,
   input  logic [NUM_LINES-1:0]               raw_i,
   output logic [NUM_CPU-1:0][NUM_LINES-1:0]  mask_o,
   output logic [NUM_CPU-1:0]                 irq_o
);
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      mask_o[c] <= '0;
         else if (we_i[c]) mask_o[c] <= wdata_i;
      end
      assign irq_o[c] = |(mask_o[c] & raw_i);
   end
endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
   import irq_router_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPU   = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               acc_en,
   input  logic                               acc_wr,
   input  logic [OFF_W-1:0]                   acc_addr,
   input  logic [HALF_W-1:0]                  acc_wdata,
   input  logic [NUM_LINES-1:0]               raw_i,
   input  logic [NUM_CPU-1:0][NUM_LINES-1:0]  mask_i,
   output logic [NUM_CPU-1:0]                 mask_we_o,
   output logic [NUM_LINES-1:0]               mask_wdata_o,
   output logic                               rsp_valid,
   output logic [HALF_W-1:0]                  rsp_rdata,
   output logic                               rsp_err
);
   logic [HALF_W-1:0] stage_q;
   logic [OFF_W-1:0]  base;
   logic              upper, aligned, hit, commit, lo_read, err_now;
   logic [REG_W-1:0]  rd_val, joined;

   assign base    = {acc_addr[OFF_W-1:3], 3'b000};
   assign upper   = acc_addr[2];
   assign aligned = (acc_addr[1:0] == 2'b00);
   assign joined  = {acc_wdata, stage_q};
   assign mask_wdata_o = joined[NUM_LINES-1:0];
   assign commit  = acc_en && acc_wr && upper;
   assign lo_read = acc_en && !acc_wr && !upper;

   always_comb begin
      hit       = 1'b0;
      rd_val    = '0;
      mask_we_o = '0;
      if (base == OFF_RAW) begin
         hit = aligned;
         rd_val[NUM_LINES-1:0] = raw_i;
      end
      for (int c = 0; c < NUM_CPU; c++) begin
         if (base == mask_off(c)) begin
            hit = aligned;
            rd_val[NUM_LINES-1:0] = mask_i[c];
            mask_we_o[c] = commit && aligned;
         end
         if (base == view_off(c)) begin
            hit = aligned;
            rd_val[NUM_LINES-1:0] = mask_i[c] & raw_i;
         end
      end
   end

   assign err_now = !hit && (commit || lo_read);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc_en;
         rsp_err   <= err_now;
         if (acc_en && acc_wr && !upper)
            stage_q <= acc_wdata;
         else if (lo_read && hit)
            stage_q <= rd_val[REG_W-1:HALF_W];
         if (acc_en && !acc_wr)
            rsp_rdata <= upper ? stage_q : (hit ? rd_val[HALF_W-1:0] : '1);
         else
            rsp_rdata <= '0;
      end
   end
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_LINES    = 64,
   parameter int NUM_CPU      = 4,
   parameter int CASCADE_LINE = 55
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 cascade_irq,
   input  logic                 acc_en,
   input  logic                 acc_wr,
   input  logic [OFF_W-1:0]     acc_addr,
   input  logic [HALF_W-1:0]    acc_wdata,
   output logic                 rsp_valid,
   output logic [HALF_W-1:0]    rsp_rdata,
   output logic                 rsp_err,
   output logic [NUM_CPU-1:0]   cpu_irq
);
   if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_lines
      $error("NUM_LINES must be 1..64");
   end
   if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("NUM_CPU must be 1..4");
   end
   if (CASCADE_LINE < 0 || CASCADE_LINE >= NUM_LINES) begin : g_bad_casc
      $error("CASCADE_LINE out of range");
   end

   logic [NUM_LINES-1:0]              raw_q;
   logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q;
   logic [NUM_CPU-1:0]                mask_we;
   logic [NUM_LINES-1:0]              mask_wdata;

   irq_raw_capture #(.NUM_LINES(NUM_LINES), .CASCADE_LINE(CASCADE_LINE)) u_raw (
      .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .cascade_i(cascade_irq),
      .raw_o(raw_q));

   irq_mask_bank #(.NUM_LINES(NUM_LINES), .NUM_CPU(NUM_CPU)) u_masks (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we), .wdata_i(mask_wdata),
      .raw_i(raw_q), .mask_o(mask_q), .irq_o(cpu_irq));

   irq_csr_port #(.NUM_LINES(NUM_LINES), .NUM_CPU(NUM_CPU)) u_csr (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .raw_i(raw_q),
      .mask_i(mask_q), .mask_we_o(mask_we), .mask_wdata_o(mask_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_LINES    = 64,
   parameter int NUM_CPU      = 4,
   parameter int CASCADE_LINE = 55
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              cascade_irq,
   input logic                              acc_en,
   input logic                              acc_wr,
   input logic [11:0]                       acc_addr,
   input logic                              rsp_valid,
   input logic [31:0]                       rsp_rdata,
   input logic                              rsp_err,
   input logic [NUM_CPU-1:0]                cpu_irq,
   input logic [NUM_LINES-1:0]              raw_q,
   input logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q
);
   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   a_r2_cascade_follows: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> raw_q[CASCADE_LINE] == $past(cascade_irq));

   a_r3_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> (cpu_irq == '0 && !rsp_valid && !rsp_err));

   a_r4_quiet_when_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q == '0) |-> (cpu_irq == '0));

   a_r6_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en && acc_wr && acc_addr[2]) |=> $stable(mask_q));

   a_r9_err_is_response: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

   a_r9_err_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && rsp_err && !$past(acc_wr)) |-> rsp_rdata == '1);
endmodule

bind irq_router irq_router_chk #(
   .NUM_LINES(NUM_LINES), .NUM_CPU(NUM_CPU), .CASCADE_LINE(CASCADE_LINE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cascade_irq(cascade_irq), .acc_en(acc_en),
   .acc_wr(acc_wr), .acc_addr(acc_addr), .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cpu_irq(cpu_irq),
   .raw_q(raw_q), .mask_q(mask_q));

// File: tb/irq_router_bench.sv
module irq_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_lines = '0;
   logic        cascade_irq = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [3:0]  cpu_irq;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [63:0] m_mask [4];

   always #5 clk = ~clk;

   irq_router u_irq_router (.*);

   function automatic logic [11:0] moff(input int c);
      return (c < 2) ? 12'h200 + 12'(c * 12'h40) : 12'h600 + 12'((c - 2) * 12'h40);
   endfunction
   function automatic logic [11:0] voff(input int c);
      return moff(c) + 12'h80;
   endfunction
   function automatic logic [63:0] exp_raw();
      logic [63:0] r = irq_lines;
      r[55] = cascade_irq;
      return r;
   endfunction
   function automatic logic [3:0] exp_irq();
      logic [3:0] e;
      for (int c = 0; c < 4; c++) e[c] = |(m_mask[c] & exp_raw());
      return e;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      rd = rsp_rdata; err = rsp_err;
      acc_en = 1'b0;
   endtask

   task automatic wr64(input logic [11:0] a, input logic [63:0] v);
      logic [31:0] rd; logic e;
      acc(1'b1, a, v[31:0], rd, e);
      acc(1'b1, a | 12'h4, v[63:32], rd, e);
   endtask

   task automatic rd64(input logic [11:0] a, output logic [63:0] v, output logic e);
      logic [31:0] lo, hi; logic e2;
      acc(1'b0, a, 32'h0, lo, e);
      acc(1'b0, a | 12'h4, 32'h0, hi, e2);
      v = {hi, lo};
   endtask

   task automatic drive_lines(input logic [63:0] l, input logic casc);
      @(negedge clk);
      irq_lines = l; cascade_irq = casc;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] v; logic e; logic [31:0] rd;
      void'($urandom(32'd20240611));
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
      irq_lines = {$urandom, $urandom};
      cascade_irq = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 irq in reset", cpu_irq, 0);
      chk("R3 rsp_valid in reset", rsp_valid, 0);
      rst_n = 1'b1;
      drive_lines('0, 1'b0);
      rd64(12'h300, v, e);
      chk("R3 raw after reset", v, 0);
      rd64(moff(2), v, e);
      chk("R3 mask after reset", v, 0);

      // random mix
      for (int it = 0; it < 40; it++) begin
         int c = int'($urandom % 4);
         logic [63:0] m = {$urandom, $urandom};
         if (it % 5 == 0) m = 64'h1 << ($urandom % 64);
         wr64(moff(c), m);
         m_mask[c] = m;
         chk("R4 irq after mask write", cpu_irq, exp_irq());
         drive_lines((it % 7 == 0) ? 64'h0 : {$urandom, $urandom} & {$urandom, $urandom},
                     1'($urandom));
         chk("R4 irq after line change", cpu_irq, exp_irq());
         rd64(12'h300, v, e);
         chk("R1 raw readback", v, exp_raw());
         rd64(voff(c), v, e);
         chk("R10 masked view", v, m_mask[c] & exp_raw());
         rd64(moff(c), v, e);
         chk("R5 mask readback", v, m_mask[c]);
         chk("R7 no error on mapped read", e, 0);
      end

      // R2: line 55 input ignored, cascade drives it
      drive_lines(64'h0080_0000_0000_0000, 1'b0);
      rd64(12'h300, v, e);
      chk("R2 line55 input ignored", v, 0);
      drive_lines('0, 1'b1);
      rd64(12'h300, v, e);
      chk("R2 cascade sets bit55", v, 64'h0080_0000_0000_0000);
      wr64(moff(3), 64'h0080_0000_0000_0000); m_mask[3] = 64'h0080_0000_0000_0000;
      chk("R4 cascade routed to cpu3", cpu_irq[3], 1);

      // R6: lower half write alone changes nothing
      wr64(moff(0), 64'h1234_5678_9abc_def0); m_mask[0] = 64'h1234_5678_9abc_def0;
      acc(1'b1, moff(0), 32'h0, rd, e);
      rd64(moff(0), v, e);
      chk("R6 low write only latches", v, 64'h1234_5678_9abc_def0);
      // R6: upper commit uses the latched low word
      acc(1'b1, moff(1), 32'h5555_aaaa, rd, e);
      acc(1'b1, moff(1) | 12'h4, 32'h0f0f_0f0f, rd, e);
      m_mask[1] = 64'h0f0f_0f0f_5555_aaaa;
      rd64(moff(1), v, e);
      chk("R6 commit joins halves", v, 64'h0f0f_0f0f_5555_aaaa);

      // R8: writes to view and raw ignored
      drive_lines(64'hffff_0000_ffff_0000, 1'b0);
      wr64(voff(0), 64'h0);
      wr64(12'h300, 64'h0);
      rd64(12'h300, v, e);
      chk("R8 raw not writable", v, 64'hff7f_0000_ffff_0000);
      rd64(voff(0), v, e);
      chk("R8 view not writable", v, m_mask[0] & 64'hff7f_0000_ffff_0000);
      chk("R8 irq unchanged", cpu_irq, exp_irq());

      // R9: unmapped read keeps latch, returns ones, one-cycle error
      acc(1'b0, moff(0), 32'h0, rd, e);
      acc(1'b0, 12'h010, 32'h0, rd, e);
      chk("R9 unmapped read data", rd, 32'hffff_ffff);
      chk("R9 unmapped read err", e, 1);
      @(negedge clk);
      chk("R9 err one cycle", rsp_err, 0);
      acc(1'b0, 12'h014, 32'h0, rd, e);
      chk("R7 hi read returns latch", rd, m_mask[0][63:32]);
      chk("R9 hi read no err", e, 0);
      acc(1'b0, moff(1) | 12'h1, 32'h0, rd, e);
      chk("R9 misaligned err", e, 1);
      acc(1'b1, 12'h014, 32'h0, rd, e);
      chk("R9 unmapped hi write err", e, 1);
      acc(1'b1, 12'h010, 32'h0, rd, e);
      chk("R9 low write no err", e, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule